// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that counts down from a programmable 24-bit period. It is clocked by one of three source-clock enables, labelled RC, main and sub. Before arming, software may set the reload period and pick the tick source.

The first write to the service register arms the watchdog for good, and the byte written becomes the key. From then on, only service writes that follow the key's rule reload the counter. A zero key expects 0x00 on every service. A nonzero key expects its bitwise inverse, then the key itself, then the inverse again, and so on.

When the count runs out, the block raises a one-cycle reset request and then holds. Clock generation and the system reset sequencer live outside the block.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is disarmed and `rst_req` is 0. While disarmed, tick enables have no effect and no request is ever raised.
- R2: `cfg_src` selects the decrementing enable: 0 = `tick_rc`, 1 = `tick_main`, 2 = `tick_sub`, 3 = none. Enables of unselected sources do not move the count.
- R3: A `cfg_wr` while disarmed stores `cfg_period` and `cfg_src`, and a period of 0 is stored as 1. A `cfg_wr` while armed is ignored.
- R4: A `clr_wr` while disarmed arms the watchdog, takes `clr_data` as the key and loads the counter with the stored period. If `cfg_wr` arrives in the same cycle, the arming uses the period stored before that cycle.
- R5: With key 0x00, each `clr_wr` of 0x00 reloads the counter, and any other value is ignored.
- R6: With a nonzero key K, valid services alternate: the first expects ~K, the next expects K, then ~K, and so on. Each valid service reloads the counter.
- R7: A service write that does not match the expected value is ignored. It neither reloads the counter nor advances the alternation.
- R8: The count falls by one on each selected tick. `rst_req` is high for exactly the one cycle after the edge at which the count reaches zero. The count then holds at zero, and no further request or service is accepted.
- R9: Once armed, nothing but the block reset disarms the watchdog. Further service writes, valid or not, never restart the arming sequence.
- R10: When a valid service and a selected tick arrive in the same cycle, the reload wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_period | input | 24 | Reload period written by `cfg_wr` |
| cfg_src | input | 2 | Tick source written by `cfg_wr` |
| clr_wr | input | 1 | Service/arming register write strobe |
| clr_data | input | 8 | Service/arming write data |
| tick_rc | input | 1 | RC clock enable |
| tick_main | input | 1 | Main clock enable |
| tick_sub | input | 1 | Sub clock enable |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest state to reach from the ports is the expected-value phase of a nonzero key after a mix of good and bad service writes. The phase is invisible and shows only through whether the count reaches zero on time.

The stimulus therefore uses short random periods and random tick patterns. It issues service writes that are half correct for the current phase and half random. This drives long runs of alternation, rejected writes and reload/tick collisions, and every episode can still end in an observable expiry.

Directed sequences add the cases random data rarely hits:
- a write of the key itself in the complement phase;
- period zero;
- configuration writes after arming;
- service writes after expiry.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    parameter int CNT_W = 24;
    parameter int KEY_W = 8;
    parameter int N_SRC = 3;
    localparam int SEL_W = $clog2(N_SRC + 1);
    parameter logic [CNT_W-1:0] RST_PERIOD = {CNT_W{1'b1}};

    typedef enum logic [SEL_W-1:0] {
        SRC_RC   = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_SUB  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [SEL_W-1:0] src;
    } cfg_st_t;

    typedef struct packed {
        logic             armed;
        logic [KEY_W-1:0] key;
        logic             phase;
    } key_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_st_t;
endpackage

// File: rtl/kwd_tick_sel.sv
module kwd_tick_sel
    import kwd_pkg::*;
(
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = ticks[i] && (sel == SEL_W'(i));
    end

    assign tick = |hit;
endmodule

// File: rtl/kwd_key_ctrl.sv
module kwd_key_ctrl
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_wr,
    input  logic [KEY_W-1:0] clr_data,
    input  logic             cnt_zero,
    output logic             arm_evt,
    output logic             svc_ok,
    output logic             armed,
    output logic             phase
);
    key_st_t          st_d, st_q;
    logic [KEY_W-1:0] expect_val;

    always_comb begin
        if (st_q.key == '0)
            expect_val = '0;
        else if (st_q.phase)
            expect_val = st_q.key;
        else
            expect_val = ~st_q.key;

        arm_evt = clr_wr && !st_q.armed;
        svc_ok  = clr_wr && st_q.armed && !cnt_zero && (clr_data == expect_val);

        st_d = st_q;
        if (arm_evt) begin
            st_d.armed = 1'b1;
            st_d.key   = clr_data;
            st_d.phase = 1'b0;
        end else if (svc_ok && (st_q.key != '0)) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign armed = st_q.armed;
    assign phase = st_q.phase;
endmodule

// File: rtl/kwd_down_cnt.sv
module kwd_down_cnt
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] period,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (load) begin
            st_d.cnt = period;
        end else if (run && tick && (st_q.cnt != '0)) begin
            st_d.cnt   = st_q.cnt - 1'b1;
            st_d.pulse = (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign expire = st_q.pulse;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [SEL_W-1:0] cfg_src,
    input  logic             clr_wr,
    input  logic [KEY_W-1:0] clr_data,
    input  logic             tick_rc,
    input  logic             tick_main,
    input  logic             tick_sub,
    output logic             rst_req
);
    cfg_st_t          cfg_d, cfg_q;
    logic             tick, arm_evt, svc_ok, armed, phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period_q;

    // Configuration is writable only while disarmed.
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr && !armed) begin
            cfg_d.period = (cfg_period == '0) ? CNT_W'(1) : cfg_period;
            cfg_d.src    = cfg_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.period <= RST_PERIOD;
            cfg_q.src    <= SRC_RC;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign period_q = cfg_q.period;

    kwd_tick_sel u_sel (
        .ticks ({tick_sub, tick_main, tick_rc}),
        .sel   (cfg_q.src),
        .tick  (tick)
    );

    kwd_key_ctrl u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .cnt_zero (cnt == '0),
        .arm_evt  (arm_evt),
        .svc_ok   (svc_ok),
        .armed    (armed),
        .phase    (phase)
    );

    kwd_down_cnt u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (armed),
        .load   (arm_evt || svc_ok),
        .period (period_q),
        .tick   (tick),
        .cnt    (cnt),
        .expire (rst_req)
    );
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
    import kwd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             armed,
    input logic             phase,
    input logic             tick,
    input logic             clr_wr,
    input logic             svc_ok,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period_q,
    input logic             rst_req
);
    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8
    pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0 && armed));

    // R8
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt == '0) |=> (cnt == '0));

    // R9
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R3
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(period_q));

    // R3
    period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_q != '0);

    // R7
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && clr_wr && !svc_ok && !tick) |=> ($stable(cnt) && $stable(phase)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !rst_req);
endmodule

bind keyed_wdog kwd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .phase    (phase),
    .tick     (tick),
    .clr_wr   (clr_wr),
    .svc_ok   (svc_ok),
    .cnt      (cnt),
    .period_q (period_q),
    .rst_req  (rst_req)
);

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [23:0] cfg_period = '0;
    logic [1:0]  cfg_src = '0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = '0;
    logic        tick_rc = 1'b0, tick_main = 1'b0, tick_sub = 1'b0;
    logic        rst_req;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    // reference model state
    bit        m_armed, m_phase;
    bit [7:0]  m_key;
    bit [23:0] m_period, m_cnt;
    bit [1:0]  m_src;

    always #2 clk = ~clk;

    keyed_wdog uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
        .cfg_src(cfg_src), .clr_wr(clr_wr), .clr_data(clr_data),
        .tick_rc(tick_rc), .tick_main(tick_main), .tick_sub(tick_sub),
        .rst_req(rst_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic bit [7:0] want_clear();
        if (m_key == 8'h00) return 8'h00;
        return m_phase ? m_key : ~m_key;
    endfunction

    function automatic bit sel_tick(bit [1:0] s, bit rc, bit mn, bit sb);
        case (s)
            2'd0: return rc;
            2'd1: return mn;
            2'd2: return sb;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(bit act, bit exp, string tag);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: rst_req actual=%0b expected=%0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_wr = 0; clr_wr = 0; tick_rc = 0; tick_main = 0; tick_sub = 0;
        m_armed = 0; m_phase = 0; m_key = 0; m_period = 24'hFFFFFF; m_cnt = 0; m_src = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check(rst_req, 1'b0, "R1"); // reset state
    endtask

    // one cycle: drive at the falling edge, advance the model, sample after the rising edge
    task automatic step(bit cw, bit [23:0] cp, bit [1:0] cs, bit kw, bit [7:0] kd,
                        bit rc, bit mn, bit sb, string force_tag);
        bit        exp_req, tk, valid;
        bit [23:0] old_p;
        string     tag;
        @(negedge clk);
        cfg_wr = cw; cfg_period = cp; cfg_src = cs; clr_wr = kw; clr_data = kd;
        tick_rc = rc; tick_main = mn; tick_sub = sb;
        exp_req = 0;
        tk = sel_tick(m_src, rc, mn, sb);
        old_p = m_period;
        tag = "R2";
        if (!m_armed) begin
            tag = "R1";
            if (cw) begin
                m_period = (cp == 0) ? 24'd1 : cp;
                m_src = cs;
                tag = "R3";
            end
            if (kw) begin
                m_armed = 1; m_key = kd; m_phase = 0; m_cnt = old_p;
                tag = "R4";
            end
        end else begin
            valid = kw && (m_cnt != 0) && (kd == want_clear());
            if (cw) tag = "R3";
            if (valid) begin
                tag = tk ? "R10" : ((m_key == 0) ? "R5" : "R6");
                m_cnt = m_period;
                if (m_key != 0) m_phase = ~m_phase;
            end else begin
                if (kw) tag = (m_cnt == 0) ? "R8" : "R7";
                if (tk && m_cnt != 0) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin exp_req = 1; tag = "R8"; end
                end else if (m_cnt == 0) begin
                    tag = "R8";
                end
            end
        end
        if (force_tag != "") tag = force_tag;
        @(posedge clk); #0.5;
        check(rst_req, exp_req, tag);
        cfg_wr = 0; clr_wr = 0;
    endtask

    task automatic idle(int n, bit rc, bit mn, bit sb, string t);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, rc, mn, sb, t);
    endtask

    initial begin
        void'($urandom(32'd4242));

        // R1: disarmed block ignores ticks
        do_reset();
        idle(8, 1, 1, 1, "R1");

        // R2, R4, R8: main source, key 0x5A, period 3
        step(1, 24'd3, 2'd1, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 8'h5A, 0, 0, 0, "R4");
        idle(5, 1, 0, 1, "R2");
        idle(2, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R8");      // third tick: pulse expected
        idle(4, 1, 1, 1, "R8");                  // held at zero, no second pulse
        step(0, 0, 0, 1, 8'hA5, 0, 1, 0, "R8");  // service after expiry ignored
        step(0, 0, 0, 1, 8'h5A, 0, 1, 0, "R9");  // no re-arm
        idle(3, 0, 1, 0, "R9");

        // R3: period 0 behaves as 1, sub source
        do_reset();
        step(1, 24'd0, 2'd2, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 8'h00, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R3");

        // R3 lock, R5 zero key, R10 collision
        do_reset();
        step(1, 24'd4, 2'd0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 8'h00, 0, 0, 0, "R4");
        step(1, 24'd100, 2'd3, 0, 0, 1, 0, 0, "R3");
        idle(1, 1, 0, 0, "R2");
        step(0, 0, 0, 1, 8'h00, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 8'h01, 1, 0, 0, "R5");  // wrong value for zero key
        idle(2, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8");

        // R6, R7: nonzero key alternation
        do_reset();
        step(1, 24'd3, 2'd0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 8'hC3, 0, 0, 0, "R4");
        idle(1, 1, 0, 0, "R2");
        step(0, 0, 0, 1, 8'hC3, 0, 0, 0, "R7");  // key itself when complement due
        step(0, 0, 0, 1, 8'h3C, 0, 0, 0, "R6");
        step(0, 0, 0, 1, 8'h3C, 0, 0, 0, "R7");  // complement repeated
        idle(2, 1, 0, 0, "R6");
        step(0, 0, 0, 1, 8'hC3, 0, 0, 0, "R6");
        idle(2, 1, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8");

        // random episodes
        for (int ep = 0; ep < 60; ep++) begin
            do_reset();
            step(1, 24'(1 + $urandom % 12), 2'($urandom % 4), 0, 0, 0, 0, 0, "");
            step(0, 0, 0, 1, (($urandom % 3) == 0) ? 8'h00 : 8'($urandom), 0, 0, 0, "");
            for (int c = 0; c < 150; c++) begin
                bit        kw = ($urandom % 5) == 0;
                bit [7:0]  kd = ($urandom % 2) ? want_clear() : 8'($urandom);
                bit        cw = ($urandom % 20) == 0;
                step(cw, 24'($urandom % 8), 2'($urandom % 4), kw, kd,
                     1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), "");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule